// File: doc/BRIEF.md
# Double-Buffered Sector Write Controller

This block manages writes into a flash array that is organised as 264-byte sectors. A host first fills a working SRAM one byte at a time. It then issues a sector-write request. On the clock edge that accepts the request, the whole SRAM is copied into a separate program buffer. The controller then runs a timed cycle from that buffer: the target sector is automatically erased, and then it is programmed byte by byte. During that cycle the array reports busy and refuses reads and further writes. The SRAM stays fully usable, so the next sector's data can be staged while the current one programs.

A write is refused when the write-protect pin is low, which locks every sector. It is also refused when the target sector falls inside a configured inclusive range `[prot_lo, prot_hi]`. Range protection is disabled whenever `prot_lo > prot_hi`. A refused write leaves the array untouched, starts no busy cycle and raises a status bit. A request that arrives while busy is dropped and flagged; it is not queued.

The array is modelled as a register memory holding `MODEL_SECTORS` sectors; the low-order sector index (index modulo `MODEL_SECTORS`) selects the stored sector. Programming can only clear bits (cell AND data), so the automatic erase to 0xFF is what makes the written data appear. The controller FSM has four states:
- `ST_IDLE`: moves to `ST_ERASE` on an accepted request.
- `ST_ERASE`: erases the whole target sector in one cycle, then always moves to `ST_PROG`.
- `ST_PROG`: writes one program-buffer byte per cycle, and moves to `ST_SETTLE` after byte 263.
- `ST_SETTLE`: waits for the busy timer to expire, then returns to `ST_IDLE`.

Top module: `sector_wr_ctrl`

## Requirements
- R1: After reset `busy_o` is 0, `status_o` is 0, every SRAM and program-buffer byte reads 0x00, and every array byte reads 0xFF.
- R2: An SRAM write (`sram_we`=1) stores `sram_wdata` at `sram_addr` (0..263) on the clock edge. `sram_rdata` shows the byte at `sram_addr` one cycle after the address is presented.
- R3: A request accepted at clock edge N drives `busy_o` high after edge N. `busy_o` falls exactly after edge N+PROG_CYCLES. PROG_CYCLES is raised to at least 266 if it is set lower.
- R4: When the cycle ends, all 264 bytes of the target sector equal the SRAM contents as they stood just before the accepting edge. SRAM writes made after that edge do not change the result.
- R5: Each accepted write erases the whole target sector to 0xFF before the first program step. Writing 0x0F over a sector that holds 0xF0 therefore yields 0x0F, not 0x00.
- R6: While `busy_o` is high, SRAM writes and reads behave exactly as in R2.
- R7: A read request (`rd_req`) while idle gives `rd_valid`=1 and the array byte on `rd_data` one cycle later. A read request while busy gives `rd_reject`=1 and `rd_valid`=0 one cycle later.
- R8: While `wp_n` is 0, a request to any sector is refused. The refusal sets `status_o[1]`, leaves `busy_o` at 0 and leaves the sector contents unchanged.
- R9: While `wp_n` is 1, a request is refused (as in R8) exactly when `prot_lo <= wr_sector <= prot_hi`. If `prot_lo > prot_hi`, no sector is range-protected.
- R10: A request made while busy sets `status_o[2]`, is not queued, and does not change when the running cycle ends.
- R11: `status_o[0]` equals `busy_o`. Each request rewrites `status_o[2:1]` with its own outcome, so an accepted request clears both bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n | input | 1 | Write-protect pin, low locks all sectors |
| prot_lo | input | SECT_W | Lower bound of protected sector range (inclusive) |
| prot_hi | input | SECT_W | Upper bound of protected sector range (inclusive) |
| sram_we | input | 1 | SRAM byte write strobe |
| sram_addr | input | 9 | SRAM byte address, 0..263 |
| sram_wdata | input | 8 | SRAM write data |
| sram_rdata | output | 8 | SRAM read data, one cycle after the address |
| wr_req | input | 1 | Sector-write request pulse |
| wr_sector | input | SECT_W | Target sector of the write |
| rd_req | input | 1 | Array byte read request |
| rd_sector | input | SECT_W | Sector to read |
| rd_byte | input | 9 | Byte within the sector, 0..263 |
| rd_data | output | 8 | Array read data |
| rd_valid | output | 1 | Read served, `rd_data` valid |
| rd_reject | output | 1 | Read refused because the array was busy |
| busy_o | output | 1 | Ready/busy output, high during a write cycle |
| status_o | output | 3 | Bit0 busy, bit1 protection refusal, bit2 request-while-busy refusal |

## Verification
The assertions assume the following about the inputs:
- `wr_req` and `rd_req` are single-cycle strobes.
- `sram_addr` and `rd_byte` stay below 264.
- `wp_n` and the protection bounds are steady in the cycle a request is sampled.

Under those assumptions the properties relate a request to the busy pin and status bits on the following edge, and a busy-span counter checks the length of the cycle. The stimulus changes every input one time unit after a rising edge and holds each strobe for exactly one cycle. It uses only in-range byte addresses, and it sets the protection inputs before raising the request.

// File: rtl/swc_pkg.sv
package swc_pkg;
    localparam int SECTOR_BYTES = 264;
    localparam int BYTE_AW      = $clog2(SECTOR_BYTES);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ERASE,
        ST_PROG,
        ST_SETTLE
    } wr_state_e;

    typedef struct packed {
        logic busy_rej;
        logic prot_rej;
    } req_flags_t;
endpackage

// File: rtl/swc_dbuf.sv
module swc_dbuf
    import swc_pkg::*;
#(
    parameter int DEPTH = SECTOR_BYTES,
    parameter int AW    = BYTE_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    input  logic          snap,
    input  logic [AW-1:0] pb_addr,
    output logic [7:0]    pb_data
);
    logic [7:0] sram_q [DEPTH];
    logic [7:0] pbuf_q [DEPTH];
    logic       addr_ok;

    assign addr_ok = int'(addr) < DEPTH;

    // working SRAM, one port for the host
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) sram_q[i] <= '0;
            rdata <= '0;
        end else begin
            if (we && addr_ok) sram_q[addr] <= wdata;
            rdata <= addr_ok ? sram_q[addr] : 8'h00;
        end
    end

    // program buffer: whole-sector snapshot in one edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) pbuf_q[i] <= '0;
        end else if (snap) begin
            for (int i = 0; i < DEPTH; i++) pbuf_q[i] <= sram_q[i];
        end
    end

    assign pb_data = (int'(pb_addr) < DEPTH) ? pbuf_q[pb_addr] : 8'h00;

    AST_SNAP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        snap && !we |=> pbuf_q[addr] == sram_q[addr]) else $error("snapshot mismatch"); // R4
endmodule

// File: rtl/swc_guard.sv
module swc_guard #(
    parameter int SW = 9
) (
    input  logic          wp_n,
    input  logic [SW-1:0] lo,
    input  logic [SW-1:0] hi,
    input  logic [SW-1:0] sector,
    output logic          locked
);
    logic range_on;
    logic in_range;

    assign range_on = lo <= hi;
    assign in_range = range_on && (sector >= lo) && (sector <= hi);
    assign locked   = !wp_n || in_range;
endmodule

// File: rtl/swc_array.sv
module swc_array
    import swc_pkg::*;
#(
    parameter int NSEC = 4,
    parameter int SW   = 9,
    parameter int AW   = BYTE_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          erase_en,
    input  logic [SW-1:0] erase_sec,
    input  logic          prog_en,
    input  logic [SW-1:0] prog_sec,
    input  logic [AW-1:0] prog_byte,
    input  logic [7:0]    prog_data,
    input  logic          rd_en,
    input  logic [SW-1:0] rd_sec,
    input  logic [AW-1:0] rd_byte,
    output logic [7:0]    rd_data
);
    localparam int CELLS = NSEC * SECTOR_BYTES;

    logic [7:0] cell_q [CELLS];
    int ebase;
    int pidx;
    int ridx;

    function automatic int cell_of(input logic [SW-1:0] s, input logic [AW-1:0] b);
        int bb;
        bb = (int'(b) < SECTOR_BYTES) ? int'(b) : 0;
        return (int'(s) % NSEC) * SECTOR_BYTES + bb;
    endfunction

    always_comb begin
        ebase = (int'(erase_sec) % NSEC) * SECTOR_BYTES;
        pidx  = cell_of(prog_sec, prog_byte);
        ridx  = cell_of(rd_sec, rd_byte);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < CELLS; c++) cell_q[c] <= 8'hFF;
            rd_data <= 8'hFF;
        end else begin
            if (erase_en) begin
                for (int b = 0; b < SECTOR_BYTES; b++) cell_q[ebase + b] <= 8'hFF;
            end else if (prog_en) begin
                // program may only clear bits
                cell_q[pidx] <= cell_q[pidx] & prog_data;
            end
            if (rd_en) rd_data <= cell_q[ridx];
        end
    end

    AST_ERASE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_en) |-> $past(erase_en) && $past(erase_sec) == prog_sec) else $error("program without erase"); // R5
    AST_ERASE_PROG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(erase_en && prog_en)) else $error("erase and program together"); // R5
endmodule

// File: rtl/sector_wr_ctrl.sv
module sector_wr_ctrl
    import swc_pkg::*;
#(
    parameter int SECT_W        = 9,
    parameter int MODEL_SECTORS = 4,
    parameter int PROG_CYCLES   = 300
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wp_n,
    input  logic [SECT_W-1:0]    prot_lo,
    input  logic [SECT_W-1:0]    prot_hi,
    input  logic                 sram_we,
    input  logic [BYTE_AW-1:0]   sram_addr,
    input  logic [7:0]           sram_wdata,
    output logic [7:0]           sram_rdata,
    input  logic                 wr_req,
    input  logic [SECT_W-1:0]    wr_sector,
    input  logic                 rd_req,
    input  logic [SECT_W-1:0]    rd_sector,
    input  logic [BYTE_AW-1:0]   rd_byte,
    output logic [7:0]           rd_data,
    output logic                 rd_valid,
    output logic                 rd_reject,
    output logic                 busy_o,
    output logic [2:0]           status_o
);
    localparam int MIN_CYC  = SECTOR_BYTES + 2;
    localparam int BUSY_CYC = (PROG_CYCLES < MIN_CYC) ? MIN_CYC : PROG_CYCLES;
    localparam int TW       = $clog2(BUSY_CYC + 1);
    localparam logic [BYTE_AW-1:0] LAST_BYTE = BYTE_AW'(SECTOR_BYTES - 1);

    wr_state_e           state_q, state_d;
    logic [TW-1:0]       tmr_q;
    logic [BYTE_AW-1:0]  pidx_q;
    logic [SECT_W-1:0]   tgt_q;
    req_flags_t          flags_q;
    logic                locked;
    logic                idle;
    logic                accept, refuse, collide;
    logic                erase_en, prog_en, arr_rd;
    logic [7:0]          pb_data;

    swc_guard #(.SW(SECT_W)) guard_i (
        .wp_n   (wp_n),
        .lo     (prot_lo),
        .hi     (prot_hi),
        .sector (wr_sector),
        .locked (locked)
    );

    swc_dbuf #(.DEPTH(SECTOR_BYTES), .AW(BYTE_AW)) dbuf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (sram_we),
        .addr    (sram_addr),
        .wdata   (sram_wdata),
        .rdata   (sram_rdata),
        .snap    (accept),
        .pb_addr (pidx_q),
        .pb_data (pb_data)
    );

    swc_array #(.NSEC(MODEL_SECTORS), .SW(SECT_W), .AW(BYTE_AW)) array_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .erase_en  (erase_en),
        .erase_sec (tgt_q),
        .prog_en   (prog_en),
        .prog_sec  (tgt_q),
        .prog_byte (pidx_q),
        .prog_data (pb_data),
        .rd_en     (arr_rd),
        .rd_sec    (rd_sector),
        .rd_byte   (rd_byte),
        .rd_data   (rd_data)
    );

    assign idle    = state_q == ST_IDLE;
    assign accept  = wr_req && idle && !locked;
    assign refuse  = wr_req && idle && locked;
    assign collide = wr_req && !idle;
    assign arr_rd  = rd_req && idle;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_ERASE;
            ST_ERASE:  state_d = ST_PROG;
            ST_PROG:   if (pidx_q == LAST_BYTE) state_d = ST_SETTLE;
            ST_SETTLE: if (tmr_q == '0) state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // timer, byte pointer, target, request flags, read handshake
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q     <= '0;
            pidx_q    <= '0;
            tgt_q     <= '0;
            flags_q   <= '0;
            rd_valid  <= 1'b0;
            rd_reject <= 1'b0;
        end else begin
            if (accept)                       tmr_q <= TW'(BUSY_CYC - 1);
            else if (!idle && tmr_q != '0)    tmr_q <= tmr_q - 1'b1;
            if (state_q == ST_ERASE)          pidx_q <= '0;
            else if (state_q == ST_PROG)      pidx_q <= pidx_q + 1'b1;
            if (accept)                       tgt_q <= wr_sector;
            if (wr_req) begin
                flags_q.busy_rej <= collide;
                flags_q.prot_rej <= refuse;
            end
            rd_valid  <= rd_req && idle;
            rd_reject <= rd_req && !idle;
        end
    end

    // outputs
    always_comb begin
        busy_o   = !idle;
        erase_en = state_q == ST_ERASE;
        prog_en  = state_q == ST_PROG;
        status_o = {flags_q.busy_rej, flags_q.prot_rej, busy_o};
    end

    // busy-span counter for checking only
    logic [TW-1:0] chk_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      chk_run_q <= '0;
        else if (busy_o) chk_run_q <= chk_run_q + 1'b1;
        else             chk_run_q <= '0;
    end

    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> chk_run_q == TW'(BUSY_CYC)) else $error("busy span"); // R3
    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && !busy_o && !locked |=> busy_o && status_o[2:1] == 2'b00) else $error("accept"); // R11
    AST_PROT_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && !busy_o && locked |=> !busy_o && status_o[1]) else $error("protect"); // R9
    AST_WP_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && !wp_n |=> !$rose(busy_o)) else $error("wp"); // R8
    AST_NO_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && busy_o |=> status_o[2]) else $error("collision"); // R10
    AST_READ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && busy_o |=> rd_reject && !rd_valid) else $error("read while busy"); // R7
endmodule

// File: tb/sector_wr_ctrl_tb_top.sv
module sector_wr_ctrl_tb_top;
    localparam int SW = 9;
    localparam int P  = 300;
    localparam int NB = 264;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wp_n = 1'b1;
    logic [SW-1:0] prot_lo = '1;
    logic [SW-1:0] prot_hi = '0;
    logic          sram_we = 1'b0;
    logic [8:0]    sram_addr = '0;
    logic [7:0]    sram_wdata = '0;
    logic [7:0]    sram_rdata;
    logic          wr_req = 1'b0;
    logic [SW-1:0] wr_sector = '0;
    logic          rd_req = 1'b0;
    logic [SW-1:0] rd_sector = '0;
    logic [8:0]    rd_byte = '0;
    logic [7:0]    rd_data;
    logic          rd_valid, rd_reject, busy_o;
    logic [2:0]    status_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sector_wr_ctrl #(.SECT_W(SW), .MODEL_SECTORS(4), .PROG_CYCLES(P)) dut_i (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .prot_lo(prot_lo), .prot_hi(prot_hi),
        .sram_we(sram_we), .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
        .wr_req(wr_req), .wr_sector(wr_sector), .rd_req(rd_req), .rd_sector(rd_sector),
        .rd_byte(rd_byte), .rd_data(rd_data), .rd_valid(rd_valid), .rd_reject(rd_reject),
        .busy_o(busy_o), .status_o(status_o)
    );

    // {wp_n, lo, hi, sector, accepted}
    localparam logic [28:0] VEC [7] = '{
        {1'b1, 9'd10, 9'd20, 9'd9,  1'b1},
        {1'b1, 9'd10, 9'd20, 9'd10, 1'b0},
        {1'b1, 9'd10, 9'd20, 9'd20, 1'b0},
        {1'b1, 9'd10, 9'd20, 9'd21, 1'b1},
        {1'b0, 9'd10, 9'd20, 9'd3,  1'b0},
        {1'b1, 9'd30, 9'd5,  9'd15, 1'b1},
        {1'b0, 9'd30, 9'd5,  9'd15, 1'b0}
    };

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((i * 7 + seed * 13) & 255);
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sram_wr(input int a, input logic [7:0] d);
        sram_we = 1'b1; sram_addr = 9'(a); sram_wdata = d;
        step();
        sram_we = 1'b0;
    endtask

    task automatic fill(input int seed, input int konst);
        for (int i = 0; i < NB; i++) sram_wr(i, (konst >= 0) ? 8'(konst) : pat(seed, i));
    endtask

    task automatic request(input int s);
        wr_req = 1'b1; wr_sector = SW'(s);
        step();
        wr_req = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy_o) step();
    endtask

    task automatic arr_rd(input int s, input int b);
        rd_req = 1'b1; rd_sector = SW'(s); rd_byte = 9'(b);
        step();
        rd_req = 1'b0;
    endtask

    task automatic check_sector(input int s, input int seed, input int konst, input string req);
        int bad = 0;
        int first_a = 0;
        int first_e = 0;
        for (int i = 0; i < NB; i++) begin
            logic [7:0] e;
            e = (konst >= 0) ? 8'(konst) : pat(seed, i);
            arr_rd(s, i);
            if (!rd_valid || rd_data !== e) begin
                if (bad == 0) begin first_a = int'(rd_data); first_e = int'(e); end
                bad++;
            end
        end
        check(bad == 0, req, first_a, first_e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int c0;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        check(busy_o == 1'b0, "R1 busy", busy_o, 0);
        check(status_o == 3'b000, "R1 status", status_o, 0);
        sram_addr = 9'd5; step();
        check(sram_rdata == 8'h00, "R1 sram", sram_rdata, 0);
        arr_rd(2, 7);
        check(rd_valid && rd_data == 8'hFF, "R1 R7 array erased", rd_data, 8'hFF);

        // R2 SRAM byte access at the top address
        sram_wr(263, 8'hA5);
        sram_addr = 9'd263; step();
        check(sram_rdata == 8'hA5, "R2 sram readback", sram_rdata, 8'hA5);

        // R8 R9 protection table
        fill(1, -1);
        for (int v = 0; v < 7; v++) begin
            logic [28:0] t;
            t = VEC[v];
            wp_n = t[28]; prot_lo = t[27:19]; prot_hi = t[18:10];
            request(int'(t[9:1]));
            check(busy_o == t[0], "R9 R8 busy after request", busy_o, t[0]);
            check(status_o[1] == !t[0], "R9 R8 protect flag", status_o[1], !t[0]);
            wait_idle();
        end
        wp_n = 1'b1; prot_lo = '1; prot_hi = '0;

        // R3 R4 R6 R7 R10 full write with overlapping activity
        fill(3, -1);
        request(2);
        c0 = cyc;
        check(status_o == 3'b001, "R11 accepted status", status_o, 1);
        arr_rd(2, 0);
        check(rd_reject && !rd_valid, "R7 read while busy", {rd_reject, rd_valid}, 2);
        request(0);
        check(status_o[2] == 1'b1, "R10 busy collision flag", status_o, 5);
        fill(9, -1);
        sram_addr = 9'd17; step();
        check(sram_rdata == pat(9, 17), "R6 sram during busy", sram_rdata, pat(9, 17));
        check(busy_o == 1'b1, "R6 still busy", busy_o, 1);
        wait_idle();
        check(cyc - c0 == P, "R3 busy length", cyc - c0, P);
        step();
        check(busy_o == 1'b0, "R10 not queued", busy_o, 0);
        check_sector(2, 3, -1, "R4 snapshot content");
        sram_addr = 9'd200; step();
        check(sram_rdata == pat(9, 200), "R2 sram keeps new data", sram_rdata, pat(9, 200));

        // R5 automatic erase
        fill(0, 8'hF0);
        request(1);
        wait_idle();
        fill(0, 8'h0F);
        request(1);
        wait_idle();
        check_sector(1, 0, 8'h0F, "R5 erase before program");

        // R8 refused write leaves sector, R11 accepted write clears flags
        wp_n = 1'b0;
        request(2);
        check(status_o == 3'b010, "R8 wp refusal", status_o, 2);
        step();
        check(busy_o == 1'b0, "R8 no busy", busy_o, 0);
        arr_rd(2, 0);
        check(rd_data == pat(3, 0), "R8 sector unchanged", rd_data, pat(3, 0));
        wp_n = 1'b1;
        request(0);
        check(status_o == 3'b001, "R11 flags cleared", status_o, 1);
        wait_idle();
        check(status_o == 3'b000, "R11 idle status", status_o, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule